// File: doc/BRIEF.md
# FIFO UART with Flow Control

This block is an asynchronous serial port with a transmit path and a receive path, each buffered by its own 16-entry byte FIFO. Software-side logic pushes bytes into the transmit FIFO and pops received bytes from the receive FIFO. Fill counts and status flags show how far each side has progressed. The character format is taken from an 8-bit mode input. It covers 7 or 8 data bits, an optional parity bit and one or two stop bits, and it can be changed between characters while the block runs.

All bit timing is derived from a 16x oversampling tick. The tick comes either from an internal divider, producing one tick every `baud_div + 1` clock cycles, or from the rising edges of an external 16x clock input. A select input chooses between the two. Hardware flow control uses two signals. `rts` tells the far end whether the receive FIFO still has room, and `cts` holds back the transmitter when the far end cannot accept data.

The receiver qualifies a start bit at its midpoint and samples every later bit at its centre. It reports framing errors, parity errors and line breaks for the most recent frame.

Top module: `uart_flow`

## Requirements
- R1: A frame is a start bit (0), then the data bits least significant first, then optional parity, then stop bits (1). Mode bit 6 = 0 selects 8 data bits and = 1 selects 7 data bits, and the idle line is 1.
- R2: Mode bit 5 = 1 inserts a parity bit after the data. `par_odd` = 0 makes the total count of ones in data plus parity even, and = 1 makes it odd.
- R3: Mode bit 3 = 0 sends one stop bit and = 1 sends two, so back-to-back characters start 10 or 11 bit times apart in the 8-bit format without parity.
- R4: Each received character is appended to the receive FIFO. `rx_ready` is 1 while that FIFO is non-empty. After a one-cycle `rx_rd` pulse, `rx_data` holds the oldest byte on the following cycle, with bit 7 read as 0 in 7-bit mode.
- R5: Each FIFO holds 16 bytes and `tx_count`/`rx_count` show the fill level. A write to a full FIFO is dropped, and `rx_full` is 1 at 16 entries.
- R6: `tx_empty` is 1 exactly when the transmit FIFO holds no bytes.
- R7: `par_err` is set for a received frame whose parity bit disagrees with the selected even/odd rule, and cleared by the next good frame.
- R8: `frame_err` is set when the first stop bit of a received frame samples 0, and cleared by the next frame whose first stop bit is 1.
- R9: A frame in which every sampled bit, stop bits included, is 0 sets `brk_det` and is not stored. The receiver then waits for the line to return to 1 before it looks for the next start bit.
- R10: `rts` is 0 while the receive FIFO holds 14 or more bytes and 1 otherwise, updated one cycle after the count changes.
- R11: While `cts` is 0 the transmitter begins no new character and `txd` stays 1 between characters.
- R12: With `ext_sel` = 0 a tick occurs every `baud_div + 1` clock cycles. With `ext_sel` = 1 a tick occurs once per rising edge of `ext_clk16`. One bit lasts 16 ticks.
- R13: A low pulse on `rxd` that is back at 1 by the 8th tick after it was seen is discarded, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 8 | Format bits: 6 = 7-bit data, 5 = parity on, 3 = two stop bits |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| baud_div | input | DIV_W | Internal divider: tick every baud_div+1 cycles |
| ext_sel | input | 1 | 1 = use external 16x clock for the tick |
| ext_clk16 | input | 1 | External 16x bit-rate clock |
| tx_wr | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_count | output | $clog2(DEPTH)+1 | Transmit FIFO fill level |
| tx_empty | output | 1 | Transmit FIFO holds nothing |
| cts | input | 1 | 1 = far end may receive |
| txd | output | 1 | Serial output |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_data | output | 8 | Byte popped by the previous rx_rd |
| rx_count | output | $clog2(DEPTH)+1 | Receive FIFO fill level |
| rx_ready | output | 1 | Receive FIFO holds data |
| rx_full | output | 1 | Receive FIFO holds DEPTH bytes |
| frame_err | output | 1 | Last frame had a low first stop bit |
| par_err | output | 1 | Last frame had a parity mismatch |
| brk_det | output | 1 | Last frame was an all-low break |
| rxd | input | 1 | Serial input |
| rts | output | 1 | 1 = receive FIFO below the high-water level |

## Verification
The bench builds the block with its defaults: DEPTH 16, DIV_W 16 and RTS_LEVEL 14. It runs the internal divider at 1 and 3, giving 32 and 64 cycles per bit, and switches to an external 16x clock with an 8-cycle period, which gives 128 cycles per bit. The short bit time lets the bench fill both FIFOs completely within the run. That exposes the dropped 17th write, the high-water crossing between 13 and 14 entries, and full-FIFO back-pressure.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int MB_LEN7  = 6;
  localparam int MB_PAR   = 5;
  localparam int MB_STOP2 = 3;
  localparam int FRW      = 12;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic stop2;
  } fmt_t;

  function automatic fmt_t fmt_of(input logic [7:0] m);
    fmt_t f;
    f.len7   = m[MB_LEN7];
    f.par_en = m[MB_PAR];
    f.stop2  = m[MB_STOP2];
    return f;
  endfunction

  function automatic logic [3:0] data_len(input fmt_t f);
    return f.len7 ? 4'd7 : 4'd8;
  endfunction

  // start + data + parity + stops
  function automatic logic [3:0] frame_len(input fmt_t f);
    return 4'd2 + data_len(f) + {3'b0, f.par_en} + {3'b0, f.stop2};
  endfunction

  function automatic logic data_par(input fmt_t f, input logic [7:0] d, input logic odd);
    return (f.len7 ? ^d[6:0] : ^d) ^ odd;
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_wr, do_rd;

  assign do_wr = wr_en && (count != CW'(DEPTH));
  assign do_rd = rd_en && (count != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && wr_en && !rd_en) |=> count == CW'(DEPTH));
  a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd_en && !wr_en) |=> count == '0);
endmodule

// File: rtl/uart_tick.sv
module uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_sel,
  input  logic             ext_in,
  output logic             tick
);
  logic [2:0]       eq;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      eq   <= '0;
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      eq <= {eq[1:0], ext_in};
      if (ext_sel) begin
        cnt  <= '0;
        tick <= eq[1] & ~eq[2];
      end else if (cnt == div) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end

  // R12: internal divider never yields adjacent ticks unless div is 0
  a_r12_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && !ext_sel && div != '0) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [7:0] mode,
  input  logic       par_odd,
  input  logic       cts,
  input  logic       have_data,
  input  logic [7:0] head,
  output logic       pop,
  output logic       txd
);
  typedef enum logic [1:0] {T_IDLE, T_LOAD, T_SEND} tst_e;
  tst_e           st;
  fmt_t           tf;
  logic [FRW-1:0] fr, sh;
  logic [3:0]     tcnt, left;

  assign pop = (st == T_IDLE) && tick && have_data && cts;

  always_comb begin
    tf = fmt_of(mode);
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(data_len(tf))) fr[i+1] = head[i];
    if (tf.par_en) fr[data_len(tf) + 4'd1] = data_par(tf, head, par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= T_IDLE;
      txd  <= 1'b1;
      sh   <= '1;
      tcnt <= '0;
      left <= '0;
    end else begin
      case (st)
        T_IDLE: if (pop) st <= T_LOAD;
        T_LOAD: begin
          txd  <= fr[0];
          sh   <= {1'b1, fr[FRW-1:1]};
          left <= frame_len(tf) - 4'd1;
          tcnt <= '0;
          st   <= T_SEND;
        end
        default: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd15) begin
            if (left == '0) st <= T_IDLE;
            else begin
              txd  <= sh[0];
              sh   <= {1'b1, sh[FRW-1:1]};
              left <= left - 1'b1;
            end
          end
        end
      endcase
    end
  end

  a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
    (st == T_IDLE) |-> txd);
  a_r11_cts_hold: assert property (@(posedge clk) disable iff (rst)
    (st == T_IDLE && !cts) |=> (st == T_IDLE));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [7:0] mode,
  input  logic       par_odd,
  input  logic       rxd_in,
  output logic       push,
  output logic [7:0] push_data,
  output logic       ferr,
  output logic       perr,
  output logic       brk
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_BITS, R_DONE, R_HOLD} rst_e;
  rst_e           st;
  logic [1:0]     sync;
  logic           r;
  fmt_t           rf;
  logic [3:0]     cnt, idx, dl;
  logic [FRW-1:0] sh;
  logic [7:0]     dv;
  logic           pb, s1, all_low, pexp;

  assign r = sync[1];

  always_comb begin
    dl      = data_len(rf);
    dv      = rf.len7 ? {1'b0, sh[6:0]} : sh[7:0];
    pb      = sh[dl];
    s1      = sh[dl + {3'b0, rf.par_en}];
    all_low = (sh == '0);
    pexp    = data_par(rf, dv, par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= R_IDLE; sync <= 2'b11; cnt <= '0; idx <= '0; sh <= '0; rf <= '0;
      push <= 1'b0; push_data <= '0; ferr <= 1'b0; perr <= 1'b0; brk <= 1'b0;
    end else begin
      sync <= {sync[0], rxd_in};
      push <= 1'b0;
      case (st)
        R_IDLE: if (tick && !r) begin
          cnt <= 4'd1;
          st  <= R_START;
        end
        R_START: if (tick) begin
          if (cnt == 4'd7) begin
            if (!r) begin
              st <= R_BITS; cnt <= '0; idx <= '0; sh <= '0; rf <= fmt_of(mode);
            end else st <= R_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        R_BITS: if (tick) begin
          if (cnt == 4'd15) begin
            cnt     <= '0;
            sh[idx] <= r;
            if (idx == frame_len(rf) - 4'd2) st <= R_DONE;
            else idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        R_DONE: begin
          push      <= !all_low;
          push_data <= dv;
          ferr      <= !s1;
          perr      <= !all_low && rf.par_en && (pb != pexp);
          brk       <= all_low;
          st        <= R_HOLD;
        end
        default: if (r) st <= R_IDLE;
      endcase
    end
  end

  a_r9_break_not_stored: assert property (@(posedge clk) disable iff (rst)
    push |-> !brk);
  a_r8_flags_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(ferr) |-> $past(st == R_DONE));
endmodule

// File: rtl/uart_flow.sv
module uart_flow #(
  parameter int DEPTH     = 16,
  parameter int DIV_W     = 16,
  parameter int RTS_LEVEL = 14,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       mode,
  input  logic             par_odd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ext_sel,
  input  logic             ext_clk16,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic [CW-1:0]    tx_count,
  output logic             tx_empty,
  input  logic             cts,
  output logic             txd,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic [CW-1:0]    rx_count,
  output logic             rx_ready,
  output logic             rx_full,
  output logic             frame_err,
  output logic             par_err,
  output logic             brk_det,
  input  logic             rxd,
  output logic             rts
);
  logic       tick, tx_pop, rx_push;
  logic [7:0] tx_head, rx_byte;

  uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(baud_div), .ext_sel(ext_sel),
    .ext_in(ext_clk16), .tick(tick));

  uart_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr_en(tx_wr), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(tx_head), .count(tx_count));

  uart_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .par_odd(par_odd),
    .cts(cts), .have_data(!tx_empty), .head(tx_head), .pop(tx_pop), .txd(txd));

  uart_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .par_odd(par_odd),
    .rxd_in(rxd), .push(rx_push), .push_data(rx_byte),
    .ferr(frame_err), .perr(par_err), .brk(brk_det));

  uart_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr_en(rx_push), .wr_data(rx_byte),
    .rd_en(rx_rd), .rd_data(rx_data), .count(rx_count));

  assign tx_empty = (tx_count == '0);
  assign rx_ready = (rx_count != '0);
  assign rx_full  = (rx_count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) rts <= 1'b1;
    else     rts <= (rx_count < CW'(RTS_LEVEL));
  end

  a_r10_rts_high: assert property (@(posedge clk) disable iff (rst)
    (rx_count >= CW'(RTS_LEVEL)) |=> !rts);
  a_r10_rts_room: assert property (@(posedge clk) disable iff (rst)
    (rx_count < CW'(RTS_LEVEL)) |=> rts);
endmodule

// File: tb/uart_flow_test.sv
module uart_flow_test;
  logic        clk = 1'b0, rst = 1'b1, ext_clk16 = 1'b0;
  logic [7:0]  mode = '0, tx_data = '0, rx_data;
  logic        par_odd = 1'b0, ext_sel = 1'b0, tx_wr = 1'b0, cts = 1'b1, rx_rd = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [4:0]  tx_count, rx_count;
  logic        tx_empty, txd, rx_ready, rx_full, frame_err, par_err, brk_det, rts;
  logic        loopback = 1'b1, drv = 1'b1;
  logic        rxd;
  int          nchk = 0, nbad = 0, cyc = 0;
  bit          done = 1'b0;

  assign rxd = loopback ? txd : drv;

  uart_flow uut (
    .clk(clk), .rst(rst), .mode(mode), .par_odd(par_odd), .baud_div(baud_div),
    .ext_sel(ext_sel), .ext_clk16(ext_clk16), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_count(tx_count), .tx_empty(tx_empty), .cts(cts), .txd(txd),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_count(rx_count), .rx_ready(rx_ready),
    .rx_full(rx_full), .frame_err(frame_err), .par_err(par_err),
    .brk_det(brk_det), .rxd(rxd), .rts(rts));

  always #4 clk = ~clk;
  always #32 ext_clk16 = ~ext_clk16;
  always @(posedge clk) cyc <= cyc + 1;

  // {len7, par_en, stop2, odd, data}
  localparam logic [11:0] VEC [6] = '{
    {4'b0000, 8'hA5}, {4'b0100, 8'h3C}, {4'b0111, 8'h81},
    {4'b1010, 8'hF7}, {4'b1101, 8'h55}, {4'b0100, 8'h00}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act >= hi) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi - 1);
    end
  endtask

  task automatic set_fmt(input bit l7, input bit pe, input bit s2, input bit odd);
    mode = {1'b0, l7, pe, 1'b0, s2, 3'b000};
    par_odd = odd;
  endtask

  task automatic mk_frame(input bit l7, input bit pe, input bit s2, input bit odd,
                          input logic [7:0] d, output logic [11:0] f, output int n);
    f = '1; f[0] = 1'b0; n = 1;
    for (int i = 0; i < (l7 ? 7 : 8); i++) begin f[n] = d[i]; n++; end
    if (pe) begin f[n] = (l7 ? ^d[6:0] : ^d) ^ odd; n++; end
    n = n + (s2 ? 2 : 1);
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx(output logic [7:0] b);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0; b = rx_data;
  endtask

  task automatic capture_tx(input int bc, input int nb, output logic [11:0] got);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      repeat (bc) @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [11:0] f, input int n, input int bc);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin drv = f[i]; repeat (bc) @(negedge clk); end
    drv = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [11:0] f, got;
    logic [7:0]  b;
    int          n, t0, t1;
    bit          quiet;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R6 reset tx_empty", tx_empty, 1);
    chk("R5 reset tx_count", tx_count, 0);
    chk("R4 reset rx_ready", rx_ready, 0);
    chk("R10 reset rts", rts, 1);

    // table walk: loopback frames in several formats
    for (int v = 0; v < 6; v++) begin
      set_fmt(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8]);
      mk_frame(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0], f, n);
      write_tx(VEC[v][7:0]);
      capture_tx(32, n, got);
      chk("R1 R2 R3 tx frame bits", got, f);
      repeat (24) @(negedge clk);
      chk("R4 rx_count after frame", rx_count, 1);
      chk("R4 rx_ready", rx_ready, 1);
      chk("R7 par_err clean", par_err, 0);
      chk("R8 frame_err clean", frame_err, 0);
      read_rx(b);
      chk("R1 R4 rx data", b, VEC[v][11] ? {1'b0, VEC[v][6:0]} : VEC[v][7:0]);
    end

    // R3: start-to-start spacing for 1 and 2 stop bits
    for (int s = 0; s < 2; s++) begin
      set_fmt(0, 0, s[0], 0);
      write_tx(8'hFF); write_tx(8'hFF);
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      while (txd !== 1'b1) @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      t1 = cyc;
      chk_rng("R3 character spacing", t1 - t0, (10 + s) * 32, (10 + s) * 32 + 16);
      repeat ((11 + s) * 32) @(negedge clk);
      read_rx(b); read_rx(b);
      chk("R4 rx drained", rx_count, 0);
    end

    // R11/R5/R6: hold with cts low, fill transmit FIFO
    set_fmt(0, 0, 0, 0);
    cts = 1'b0;
    for (int i = 0; i < 16; i++) write_tx(8'h10 + 8'(i));
    chk("R5 tx_count full", tx_count, 16);
    chk("R6 tx_empty with data", tx_empty, 0);
    write_tx(8'hEE);
    chk("R5 tx write to full dropped", tx_count, 16);
    quiet = 1'b1;
    repeat (96) begin @(negedge clk); if (txd !== 1'b1) quiet = 1'b0; end
    chk("R11 no start while cts low", quiet, 1);
    chk("R11 tx fifo untouched", tx_count, 16);
    cts = 1'b1;
    repeat (16 * 10 * 32 + 300) @(negedge clk);
    chk("R6 tx_empty after drain", tx_empty, 1);
    chk("R5 rx_count full", rx_count, 16);
    chk("R5 rx_full", rx_full, 1);
    chk("R10 rts low when full", rts, 0);
    loopback = 1'b0;
    mk_frame(0, 0, 0, 0, 8'hEE, f, n);
    drive_frame(f, n, 32);
    chk("R5 rx write to full dropped", rx_count, 16);
    read_rx(b); chk("R4 rx order 0", b, 8'h10);
    read_rx(b); chk("R4 rx order 1", b, 8'h11);
    repeat (2) @(negedge clk);
    chk("R10 rts low at 14", rts, 0);
    read_rx(b); chk("R4 rx order 2", b, 8'h12);
    repeat (2) @(negedge clk);
    chk("R10 rts high at 13", rts, 1);
    for (int i = 3; i < 16; i++) begin
      read_rx(b);
      chk("R4 rx order rest", b, 8'h10 + 8'(i));
    end
    chk("R4 rx_ready empty", rx_ready, 0);

    // R7: parity error (even parity, data 01, parity bit 0)
    set_fmt(0, 1, 0, 0);
    f = '1; f[0] = 1'b0; f[8:1] = 8'h01; f[9] = 1'b0;
    drive_frame(f, 11, 32);
    chk("R7 par_err set", par_err, 1);
    chk("R7 frame stored", rx_count, 1);
    read_rx(b);

    // R8: framing error (8N1, stop low)
    set_fmt(0, 0, 0, 0);
    f = '1; f[0] = 1'b0; f[8:1] = 8'h5A; f[9] = 1'b0;
    drive_frame(f, 10, 32);
    chk("R8 frame_err set", frame_err, 1);
    chk("R7 par_err cleared", par_err, 0);
    read_rx(b);
    chk("R8 data kept", b, 8'h5A);
    mk_frame(0, 0, 0, 0, 8'h66, f, n);
    drive_frame(f, n, 32);
    chk("R8 frame_err cleared", frame_err, 0);
    read_rx(b);

    // R9: break in 8N2, then recovery
    set_fmt(0, 0, 1, 0);
    drive_frame(12'h000, 11, 32);
    chk("R9 brk_det set", brk_det, 1);
    chk("R9 break not stored", rx_count, 0);
    mk_frame(0, 0, 1, 0, 8'h99, f, n);
    drive_frame(f, n, 32);
    chk("R9 brk_det cleared", brk_det, 0);
    read_rx(b);
    chk("R9 recovery data", b, 8'h99);

    // R13: short low glitch
    @(negedge clk); drv = 1'b0;
    repeat (4) @(negedge clk); drv = 1'b1;
    repeat (64) @(negedge clk);
    chk("R13 glitch not stored", rx_count, 0);
    chk("R13 glitch no flag", frame_err, 0);

    // R12: external clock (128 cycles/bit), then divider 3 (64 cycles/bit)
    loopback = 1'b1;
    ext_sel = 1'b1;
    set_fmt(0, 0, 0, 0);
    mk_frame(0, 0, 0, 0, 8'hC3, f, n);
    write_tx(8'hC3);
    capture_tx(128, n, got);
    chk("R12 ext clock frame", got, f);
    repeat (96) @(negedge clk);
    read_rx(b);
    chk("R12 ext clock rx", b, 8'hC3);
    ext_sel = 1'b0;
    baud_div = 16'd3;
    set_fmt(0, 1, 0, 0);
    mk_frame(0, 1, 0, 0, 8'h3A, f, n);
    write_tx(8'h3A);
    capture_tx(64, n, got);
    chk("R12 divider frame", got, f);
    repeat (48) @(negedge clk);
    read_rx(b);
    chk("R12 divider rx", b, 8'h3A);

    finish_run();
  end
endmodule